// File: doc/BRIEF.md
# Serial Port with Modem Control

The block is an asynchronous serial transmitter and receiver. Software reaches it through byte-wide registers. Each direction has a single holding register. The character format can be set to seven or eight data bits, parity off, even or odd, and one or two stop bits. A sixteen-times oversampling tick drives both directions. The tick comes either from an internal divider, set by the baud register and the divisor nibble, or from an external strobe.

Two outputs, a request-to-send line and a data-terminal-ready line, are under software control. Two inputs, clear-to-send and data-set-ready, are synchronized and reported to software. A change on either input can raise a sticky flag. A null configuration routes the transmit line back into the receiver and crosses the two output lines over to the two inputs. When hardware flow control is selected, a character does not begin until clear-to-send is asserted. One level interrupt line combines four separately enabled causes.

Top module: `uart_mc`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0x02 (only bit 1, transmit holding empty), `txd` is high, `irq` is low, and `rts_o` and `dtr_o` are low.
- R2: A byte written to the data register (offset 0x10) is sent LSB first: one low start bit, then the data bits, an optional parity bit, and high stop bits. Each bit lasts 16 ticks. The line is high whenever no character is being shifted.
- R3: Mode register (offset 0x04) fields: bit 0 selects 7 data bits when 1 and 8 when 0; bit 1 enables parity; bit 2 selects odd parity when 1 and even when 0; bit 3 selects two stop bits when 1 and one when 0; bits 7:4 hold the divisor nibble.
- R4: A received character sets status bit 0. Reading offset 0x10 returns the character and clears bit 0, unless a new character completes in the same cycle.
- R5: Status bit 5 is set when the first stop bit samples low. Status bit 4 is set when parity is enabled and the parity bit does not match. Reading status clears both flags.
- R6: If a character completes while status bit 0 is still set and the data register is not being read, status bit 6 (overrun) is set and the held character is kept.
- R7: When control bit 3 (hardware flow) is 1, a pending character waits with `txd` high until clear-to-send is asserted.
- R8: Modem control register (offset 0x14): bit 0 drives `rts_o` and bit 1 drives `dtr_o`. Bit 3 selects the null configuration, in which the receiver hears `txd`, clear-to-send follows `rts_o` and data-set-ready follows `dtr_o`.
- R9: Modem status (offset 0x20) reads clear-to-send in bit 0 and data-set-ready in bit 1. While modem control bit 2 is set, a change on either input sets status bit 7. Reading modem status clears bit 7. With modem control bit 2 clear, a change has no effect.
- R10: `irq` is the OR of four causes, each gated by its own control enable: bit 7 with status bit 7, bit 6 with any of status bits 6:4, bit 5 with transmit holding empty, and bit 4 with receive full.
- R11: Control bit 1 enables the transmitter. While it is 0, a written byte stays pending and `txd` stays high. Control bit 0 enables the receiver.
- R12: With control bit 2 at 0, a tick occurs every (baud+1)*(divisor+1) clocks, where baud is at offset 0x08. With control bit 2 at 1, each clock in which `ext_tick` is high is a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request, active high |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| ext_tick | input | 1 | External oversampling strobe |
| rts_o | output | 1 | Request-to-send, active high |
| dtr_o | output | 1 | Data-terminal-ready, active high |
| cts_i | input | 1 | Clear-to-send, active high |
| dsr_i | input | 1 | Data-set-ready, active high |

## Verification
The following relations are checked on every cycle:
- the transmit line idles high whenever no character is shifting;
- no character starts while the transmitter is disabled;
- writes to modem control reach the two output pins one cycle later;
- a data read empties the receive buffer;
- a completion into a full buffer raises overrun;
- an interrupt never appears without an enable.

Bit order, parity sense, stop count, error detection, flow-control holding, the loopback path, modem-change reporting and the bit period for both tick sources can only be shown by the bench's scenarios. In those scenarios the bench decodes frames and computes status bytes from the requirements.

// File: rtl/uart_mc.sv
module uart_mc #(
  parameter int OVS   = 16,
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [5:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       txd,
  input  logic       rxd,
  input  logic       ext_tick,
  output logic       rts_o,
  output logic       dtr_o,
  input  logic       cts_i,
  input  logic       dsr_i
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] HALF = OW'(OVS / 2 - 1);
  localparam logic [5:0] A_CTL = 6'h00, A_MODE = 6'h04, A_BAUD = 6'h08, A_STAT = 6'h0C,
                         A_DATA = 6'h10, A_MCR = 6'h14, A_MSR = 6'h20;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic [7:0] ctl, mode, baud;
  logic [3:0] mcr;

  wire wr_en   = bus_sel & bus_wr;
  wire rd_en   = bus_sel & ~bus_wr;
  wire wr_data = wr_en && bus_addr == A_DATA;
  wire wr_mcr  = wr_en && bus_addr == A_MCR;
  wire rd_data = rd_en && bus_addr == A_DATA;
  wire rd_stat = rd_en && bus_addr == A_STAT;
  wire rd_msr  = rd_en && bus_addr == A_MSR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= '0; mode <= '0; baud <= '0; mcr <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_CTL:  ctl  <= bus_wdata;
        A_MODE: mode <= bus_wdata;
        A_BAUD: baud <= bus_wdata;
        A_MCR:  mcr  <= bus_wdata[3:0];
        default: ;
      endcase
    end

  assign rts_o = mcr[0];
  assign dtr_o = mcr[1];
  wire null_cfg = mcr[3];

  // oversampling tick
  logic [12:0] prod;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  assign prod    = ({5'b0, baud} + 13'd1) * ({9'b0, mode[7:4]} + 13'd1);
  assign pre_lim = PRE_W'(prod - 13'd1);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cnt <= '0;
    else if (pre_cnt >= pre_lim) pre_cnt <= '0;
    else pre_cnt <= pre_cnt + 1'b1;
  wire tick = ctl[2] ? ext_tick : (pre_cnt >= pre_lim);

  // input synchronizers
  logic [1:0] rx_s, cts_s, dsr_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s <= 2'b11; cts_s <= '0; dsr_s <= '0;
    end else begin
      rx_s <= {rx_s[0], rxd}; cts_s <= {cts_s[0], cts_i}; dsr_s <= {dsr_s[0], dsr_i};
    end

  wire rx_in   = null_cfg ? txd   : rx_s[1];
  wire cts_eff = null_cfg ? rts_o : cts_s[1];
  wire dsr_eff = null_cfg ? dtr_o : dsr_s[1];

  // transmitter
  logic [7:0]    thr;
  logic          thr_full, tx_busy;
  logic [11:0]   tx_sh, frame;
  logic [3:0]    tx_left, frame_len;
  logic [OW-1:0] tx_tc;
  logic          tpar;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || !mode[0]) frame[i+1] = thr[i];
    tpar = ^(thr & (mode[0] ? 8'h7F : 8'hFF)) ^ mode[2];
    if (mode[1]) frame[mode[0] ? 8 : 9] = tpar;
    frame_len = 4'd1 + (mode[0] ? 4'd7 : 4'd8) + {3'b0, mode[1]} + (mode[3] ? 4'd2 : 4'd1);
  end

  wire tx_go = ctl[1] && thr_full && !tx_busy && (!ctl[3] || cts_eff);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_busy <= 1'b0;
      tx_sh <= '1; tx_left <= '0; tx_tc <= '0;
    end else begin
      if (tx_go) begin
        tx_sh <= frame; tx_left <= frame_len; tx_tc <= '0;
        tx_busy <= 1'b1; thr_full <= 1'b0;
      end else if (tx_busy && tick) begin
        tx_tc <= tx_tc + 1'b1;
        if (tx_tc == LAST) begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end
      end
      if (wr_data) begin
        thr <= bus_wdata; thr_full <= 1'b1;
      end
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  rx_st_t        rx_st;
  logic          armed;
  logic [OW-1:0] rx_tc;
  logic [3:0]    rx_idx, rx_last;
  logic [9:0]    rx_buf;
  logic [7:0]    rx_word;
  logic          rx_pbit, rx_done, rx_perr, rx_ferr;

  assign rx_last = (mode[0] ? 4'd7 : 4'd8) + {3'b0, mode[1]};
  assign rx_done = rx_st == RX_BITS && ctl[0] && tick && rx_tc == LAST && rx_idx == rx_last;
  assign rx_word = mode[0] ? {1'b0, rx_buf[6:0]} : rx_buf[7:0];
  assign rx_pbit = mode[0] ? rx_buf[7] : rx_buf[8];
  assign rx_perr = mode[1] && (rx_pbit != (^rx_word ^ mode[2]));
  assign rx_ferr = !rx_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE; armed <= 1'b0; rx_tc <= '0; rx_idx <= '0; rx_buf <= '0;
    end else begin
      case (rx_st)
        RX_IDLE: begin
          if (rx_in) armed <= 1'b1;
          if (ctl[0] && armed && tick && !rx_in) begin
            rx_st <= RX_START; rx_tc <= '0;
          end
        end
        RX_START:
          if (!ctl[0]) rx_st <= RX_IDLE;
          else if (tick) begin
            rx_tc <= rx_tc + 1'b1;
            if (rx_tc == HALF) begin
              if (!rx_in) begin
                rx_st <= RX_BITS; rx_tc <= '0; rx_idx <= '0;
              end else rx_st <= RX_IDLE;
            end
          end
        RX_BITS:
          if (!ctl[0]) rx_st <= RX_IDLE;
          else if (tick) begin
            rx_tc <= rx_tc + 1'b1;
            if (rx_tc == LAST) begin
              rx_buf[rx_idx] <= rx_in;
              if (rx_idx == rx_last) begin
                rx_st <= RX_IDLE; armed <= 1'b0;
              end else rx_idx <= rx_idx + 1'b1;
            end
          end
        default: rx_st <= RX_IDLE;
      endcase
    end

  // status and modem change
  logic [7:0] rbr;
  logic rx_full, oe, fe, pe, mss, cts_q, dsr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbr <= '0; rx_full <= 1'b0; oe <= 1'b0; fe <= 1'b0; pe <= 1'b0;
      mss <= 1'b0; cts_q <= 1'b0; dsr_q <= 1'b0;
    end else begin
      cts_q <= cts_eff; dsr_q <= dsr_eff;
      if (rd_data) rx_full <= 1'b0;
      if (rd_stat) begin oe <= 1'b0; fe <= 1'b0; pe <= 1'b0; end
      if (rd_msr) mss <= 1'b0;
      if (rx_done) begin
        if (rx_full && !rd_data) oe <= 1'b1;
        else begin
          rbr <= rx_word; rx_full <= 1'b1;
          if (rx_ferr) fe <= 1'b1;
          if (rx_perr) pe <= 1'b1;
        end
      end
      if (mcr[2] && (cts_eff != cts_q || dsr_eff != dsr_q)) mss <= 1'b1;
    end

  wire [7:0] status = {mss, oe, fe, pe, tx_busy, rx_st != RX_IDLE, !thr_full, rx_full};

  always_comb
    case (bus_addr)
      A_CTL:   bus_rdata = ctl;
      A_MODE:  bus_rdata = mode;
      A_BAUD:  bus_rdata = baud;
      A_STAT:  bus_rdata = status;
      A_DATA:  bus_rdata = rbr;
      A_MCR:   bus_rdata = {4'b0, mcr};
      A_MSR:   bus_rdata = {6'b0, dsr_eff, cts_eff};
      default: bus_rdata = '0;
    endcase

  assign irq = (ctl[7] & mss) | (ctl[6] & (oe | fe | pe)) | (ctl[5] & ~thr_full) | (ctl[4] & rx_full);
endmodule

// File: rtl/uart_mc_chk.sv
module uart_mc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       ten,
  input logic       rd_data,
  input logic       rx_done,
  input logic       rx_full,
  input logic       oe,
  input logic       irq,
  input logic [3:0] ie,
  input logic       wr_mcr,
  input logic [1:0] wbits,
  input logic       rts_o,
  input logic       dtr_o
);
  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> txd);
  p_ten_gate_r11: assert property (@(posedge clk) disable iff (!rst_n) (!ten && !tx_busy) |=> !tx_busy);
  p_mcr_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mcr |=> (rts_o == $past(wbits[0]) && dtr_o == $past(wbits[1])));
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n) (rd_data && !rx_done) |=> !rx_full);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && rx_full && !rd_data) |=> oe);
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ie != 4'd0);
endmodule

bind uart_mc uart_mc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .ten(ctl[1]),
  .rd_data(rd_data), .rx_done(rx_done), .rx_full(rx_full), .oe(oe), .irq(irq),
  .ie(ctl[7:4]), .wr_mcr(wr_mcr), .wbits(bus_wdata[1:0]), .rts_o(rts_o), .dtr_o(dtr_o)
);

// File: tb/uart_mc_tb_top.sv
`timescale 1ns/1ps
module uart_mc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, rxd = 1, ext_tick = 0, cts_i = 0, dsr_i = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, txd, rts_o, dtr_o;
  int n_cmp = 0, n_bad = 0, per = 1;
  logic [3:0] m_mcr = '0;
  bit ext_run = 0, finished = 0;

  always #2 clk = ~clk;

  uart_mc dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .txd(txd), .rxd(rxd),
    .ext_tick(ext_tick), .rts_o(rts_o), .dtr_o(dtr_o), .cts_i(cts_i), .dsr_i(dsr_i));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock model comparison of the modem output pins
  always @(posedge clk) begin
    #1;
    if (rst_n) chk("R8 pins", {rts_o, dtr_o}, {m_mcr[0], m_mcr[1]});
  end

  initial forever begin
    @(negedge clk);
    ext_tick = ext_run ? ~ext_tick : 1'b0;
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (a == 6'h14) m_mcr = d[3:0];
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic [11:0] mk(input logic [7:0] d, input bit l7, input bit pen,
                                     input bit odd, input bit two, output int n);
    logic [11:0] f;
    int k, ones;
    f = '1; f[0] = 0; k = 1; ones = 0;
    for (int i = 0; i < (l7 ? 7 : 8); i++) begin
      f[k] = d[i]; ones += d[i]; k++;
    end
    if (pen) begin
      f[k] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1); k++;
    end
    n = k + (two ? 2 : 1);
    return f;
  endfunction

  task automatic cap_tx(input string req, input logic [11:0] exp, input int n);
    logic [11:0] got;
    got = '1;
    while (txd === 1'b1) @(negedge clk);
    repeat (8 * per - 1) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) repeat (16 * per) @(negedge clk);
    end
    for (int i = 0; i < n; i++) chk(req, got[i], exp[i]);
    repeat (16 * per) @(negedge clk);
  endtask

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (16) @(negedge clk);
    end
    rxd = 1;
  endtask

  task automatic low_run(output int d);
    d = 0;
    while (txd === 1'b1) @(negedge clk);
    while (txd === 1'b0) begin d++; @(negedge clk); end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [11:0] f;
    int n, d;
    logic cnt_low;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pins", {rts_o, dtr_o}, 2'b00);
    rd_chk("R1 status", 6'h0C, 8'h02);
    rd_chk("R1 msr", 6'h20, 8'h00);

    // R2 8N1 transmit
    wr(6'h00, 8'h03);
    wr(6'h10, 8'hA5);
    f = mk(8'hA5, 0, 0, 0, 0, n);
    cap_tx("R2 frame", f, n);
    rd_chk("R2 status idle", 6'h0C, 8'h02);

    // R11 transmitter disabled keeps byte pending
    wr(6'h00, 8'h01);
    wr(6'h10, 8'h3C);
    cnt_low = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) cnt_low = 1;
    end
    chk("R11 line held", cnt_low, 1'b0);
    rd_chk("R11 status pending", 6'h0C, 8'h00);
    wr(6'h00, 8'h03);
    f = mk(8'h3C, 0, 0, 0, 0, n);
    cap_tx("R11 released frame", f, n);

    // R3 7 bits, odd parity, two stops; then even, one stop
    wr(6'h04, 8'h0F);
    wr(6'h10, 8'h35);
    f = mk(8'h35, 1, 1, 1, 1, n);
    cap_tx("R3 7O2", f, n);
    wr(6'h04, 8'h03);
    wr(6'h10, 8'h35);
    f = mk(8'h35, 1, 1, 0, 0, n);
    cap_tx("R3 7E1", f, n);

    // R4 receive
    wr(6'h04, 8'h00);
    f = mk(8'h5A, 0, 0, 0, 0, n);
    send_rx(f, n);
    repeat (4) @(negedge clk);
    rd_chk("R4 full", 6'h0C, 8'h03);
    rd_chk("R4 data", 6'h10, 8'h5A);
    rd_chk("R4 cleared", 6'h0C, 8'h02);

    // R5 parity and framing errors
    wr(6'h04, 8'h02);
    f = mk(8'h81, 0, 1, 0, 0, n);
    f[9] = ~f[9]; f[10] = 1'b0;
    send_rx(f, n);
    repeat (4) @(negedge clk);
    rd_chk("R5 errors", 6'h0C, 8'h33);
    rd_chk("R5 errors cleared", 6'h0C, 8'h03);
    rd_chk("R5 data", 6'h10, 8'h81);

    // R6 overrun
    wr(6'h04, 8'h00);
    f = mk(8'h11, 0, 0, 0, 0, n);
    send_rx(f, n);
    f = mk(8'h22, 0, 0, 0, 0, n);
    send_rx(f, n);
    repeat (4) @(negedge clk);
    rd_chk("R6 overrun", 6'h0C, 8'h43);
    rd_chk("R6 kept first", 6'h10, 8'h11);

    // R10 interrupt causes
    wr(6'h00, 8'h13);
    chk("R10 no cause", irq, 1'b0);
    f = mk(8'h77, 0, 0, 0, 0, n);
    send_rx(f, n);
    repeat (4) @(negedge clk);
    chk("R10 rx irq", irq, 1'b1);
    rd_chk("R10 data", 6'h10, 8'h77);
    chk("R10 rx irq cleared", irq, 1'b0);
    wr(6'h00, 8'h23);
    chk("R10 tx empty irq", irq, 1'b1);
    wr(6'h00, 8'h03);
    chk("R10 disabled", irq, 1'b0);

    // R7 hardware flow control
    wr(6'h00, 8'h0B);
    cts_i = 0;
    wr(6'h10, 8'h42);
    cnt_low = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) cnt_low = 1;
    end
    chk("R7 held", cnt_low, 1'b0);
    rd_chk("R7 status", 6'h0C, 8'h00);
    cts_i = 1;
    f = mk(8'h42, 0, 0, 0, 0, n);
    cap_tx("R7 after cts", f, n);
    wr(6'h00, 8'h03);

    // R8 null configuration loopback
    wr(6'h14, 8'h0B);
    repeat (2) @(negedge clk);
    rd_chk("R8 msr crossed", 6'h20, 8'h03);
    wr(6'h10, 8'h6E);
    repeat (200) @(negedge clk);
    rd_chk("R8 loop status", 6'h0C, 8'h03);
    rd_chk("R8 loop data", 6'h10, 8'h6E);
    wr(6'h14, 8'h00);

    // R9 modem status change
    repeat (4) @(negedge clk);
    dsr_i = 1;
    repeat (4) @(negedge clk);
    rd_chk("R9 ignored without update", 6'h0C, 8'h02);
    wr(6'h14, 8'h04);
    wr(6'h00, 8'h83);
    dsr_i = 0;
    repeat (4) @(negedge clk);
    rd_chk("R9 change flag", 6'h0C, 8'h82);
    chk("R9 modem irq", irq, 1'b1);
    rd_chk("R9 msr", 6'h20, 8'h01);
    rd_chk("R9 cleared", 6'h0C, 8'h02);
    chk("R9 irq cleared", irq, 1'b0);
    wr(6'h14, 8'h00);

    // R12 internal divider: (2+1)*(1+1) = 6 clocks per tick
    wr(6'h00, 8'h03);
    wr(6'h08, 8'h02);
    wr(6'h04, 8'h10);
    wr(6'h10, 8'hFF);
    low_run(d);
    chk("R12 divided bit", (d > 90 && d <= 96), 1'b1);
    repeat (1000) @(negedge clk);
    rd_chk("R12 done", 6'h0C, 8'h02);

    // R12 external tick every 2 clocks
    ext_run = 1;
    wr(6'h04, 8'h00);
    wr(6'h00, 8'h07);
    wr(6'h10, 8'hFF);
    low_run(d);
    chk("R12 external bit", (d >= 30 && d <= 33), 1'b1);
    repeat (400) @(negedge clk);
    rd_chk("R12 ext done", 6'h0C, 8'h02);

    summary();
  end
endmodule